// File: doc/BRIEF.md
# Dual-Winding Peak-Current Chopper

This block produces fixed-frequency, peak-current-limited drive for the two windings of a stepper motor. A free-running counter divides the clock into periods of 256 clocks. At the start of each period both windings switch on together. Each winding then stays on until its own current-sense comparator reports that the winding current has reached its reference level; from then on that winding is off for the rest of the period. The comparator results come from analog circuitry outside the block, so they are synchronized on entry. For a programmable number of clocks at the start of every period they are ignored, which masks the switching spike that follows turn-on.

Each winding has a bridge-enable line (active low: low means the bridge is inhibited) and a pair of phase lines that set current direction. A per-winding decay selection chooses where the chopping is applied. In fast decay the phase pair holds its direction and the bridge-enable line is chopped. In slow decay the bridge-enable line stays high and the phase pair is chopped. Direction and decay selection are taken up only at a period boundary. A sync output goes low for the first 16 clocks of every period, and an active-low enable input forces every bridge output low when it is high.

Top module: `dual_chopper_pwm`

## Requirements
- R1: The counter restarts at position 0 after reset and counts up once per clock. sync_n is low exactly while the position is 0 to 15, and is high otherwise. While reset is held, the position stays 0.
- R2: The period is 256 clocks. At position 0 both windings are on, whatever happened in the previous period.
- R3: At position 255 both windings are off, so the on-time per period is at most 255 clocks.
- R4: A sense input passes through two flops. A high level present at rising edge k turns the winding off from rising edge k+2 onward, provided the counter position at edge k+2 is at least blank_len.
- R5: Once a winding is off, it stays off until the next position 0, even if its sense input falls again.
- R6: A synchronized sense level that arrives at an edge where the counter position is below blank_len has no effect. A blank_len of 255 disables sensing for the whole period.
- R7: Each winding turns off only because of its own sense input. A trip on one winding leaves the other winding unchanged.
- R8: In fast decay (decay_slow[w]=0) the phase pair of winding w shows its direction at all times: ph[2w]=dir, ph[2w+1]=~dir. The enable line inh_n[w] equals 1 while the winding is on and 0 while it is off.
- R9: In slow decay (decay_slow[w]=1), inh_n[w] stays 1. While the winding is on, ph[2w]=dir and ph[2w+1]=~dir. While it is off, both phase lines are 0.
- R10: The values of dir[w] and decay_slow[w] are sampled only at the edge that leads into position 0. A change at any other time first shows at the next period start. After reset, direction 0 and fast decay are in force.
- R11: While en_n is 1, inh_n and ph are all 0 in the same clock. The counter and the trip state run on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_n | input | 1 | Output enable, active low |
| sense | input | 2 | Comparator trip per winding, asynchronous |
| dir | input | 2 | Current direction per winding |
| decay_slow | input | 2 | 1 selects slow decay for the winding, 0 selects fast decay |
| blank_len | input | 8 | Blanking length in clocks from the period start |
| inh_n | output | 2 | Bridge enable per winding, low inhibits |
| ph | output | 4 | Phase lines, winding w on bits 2w and 2w+1 |
| sync_n | output | 1 | Low for the first 16 clocks of every period |

## Verification
The counter position, and with it sync_n and the period-end turn-off, is due one edge after reset release. After that it advances by one at every edge. A sense level takes effect on the drive two edges after the edge that first samples it, and only if the position at that second edge has passed the blanking length. Direction and decay changes wait for the edge into position 0, while en_n acts on the outputs in the same clock. The bench keeps its own position, two-stage sense history, trip flags and latched settings, all updated at the rising edge from the inputs it drove half a clock earlier. It compares every output at the falling edge, so each expected value already accounts for these latencies.

// File: rtl/chop_pkg.sv
package chop_pkg;

  // Output state of one bridge: enable line plus the two phase lines
  typedef struct packed {
    logic en_line;
    logic ph_hi;
    logic ph_lo;
  } bridge_t;

  // Map drive state, direction and decay style onto the bridge lines
  function automatic bridge_t steer(input logic on, input logic dir,
                                    input logic slow, input logic off_all);
    bridge_t b;
    if (off_all) begin
      b = '0;
    end else if (slow) begin
      b.en_line = 1'b1;
      b.ph_hi   = dir & on;
      b.ph_lo   = ~dir & on;
    end else begin
      b.en_line = on;
      b.ph_hi   = dir;
      b.ph_lo   = ~dir;
    end
    return b;
  endfunction

  // True while the position lies inside the sync window
  function automatic logic in_window(input int unsigned pos, input int unsigned len);
    return pos < len;
  endfunction

endpackage

// File: rtl/period_counter.sv
module period_counter #(
  parameter int CNT_W    = 8,
  parameter int SYNC_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] pos,
  output logic             wrap,
  output logic             sync_n
);
  import chop_pkg::*;

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos + 1'b1;
  end

  assign wrap   = (pos == LAST);
  assign sync_n = ~in_window(32'(pos), SYNC_LEN);

  // R2: the period end is always followed by position 0
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pos == '0));

  // R1: sync goes low only when a new period begins
  a_r1_sync_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_n && $past(sync_n)) |-> (pos == '0));

endmodule

// File: rtl/sense_gate.sv
module sense_gate #(
  parameter int CNT_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sense_raw,
  input  logic             wrap,
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] blank_len,
  output logic             tripped
);
  logic [STAGES-1:0] sh;
  logic              sense_s;
  logic              window_open;
  logic              sense_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], sense_raw};
  end

  assign sense_s     = sh[STAGES-1];
  assign window_open = (pos >= blank_len);
  assign sense_seen  = sense_s & window_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tripped <= 1'b0;
    else if (wrap) tripped <= 1'b0;
    else if (sense_seen) tripped <= 1'b1;
  end

  // R5: a trip holds until the period ends
  a_r5_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tripped && !wrap) |=> tripped);

  // R6: no trip can start inside the blanking window
  a_r6_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tripped && (pos < blank_len)) |=> !tripped);

endmodule

// File: rtl/bridge_steer.sv
module bridge_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic tripped,
  input  logic dir,
  input  logic slow,
  input  logic en_n,
  output logic en_line,
  output logic ph_hi,
  output logic ph_lo
);
  import chop_pkg::*;

  logic    dir_q;
  logic    slow_q;
  logic    drive_on;
  bridge_t b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      slow_q <= 1'b0;
    end else if (wrap) begin
      dir_q  <= dir;
      slow_q <= slow;
    end
  end

  assign drive_on = ~tripped & ~wrap;
  assign b        = steer(drive_on, dir_q, slow_q, en_n);
  assign en_line  = b.en_line;
  assign ph_hi    = b.ph_hi;
  assign ph_lo    = b.ph_lo;

  // R11: disabled bridge has every line low
  a_r11_disable: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (!en_line && !ph_hi && !ph_lo));

  // R9: slow decay never drops the enable line while outputs are enabled
  a_r9_slow_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_q && !en_n) |-> en_line);

  // R10: latched settings only move at the period boundary
  a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> ($stable(dir_q) && $stable(slow_q)));

endmodule

// File: rtl/dual_chopper_pwm.sv
module dual_chopper_pwm #(
  parameter int CNT_W       = 8,
  parameter int SYNC_LEN    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n,
  input  logic [1:0]       sense,
  input  logic [1:0]       dir,
  input  logic [1:0]       decay_slow,
  input  logic [CNT_W-1:0] blank_len,
  output logic [1:0]       inh_n,
  output logic [3:0]       ph,
  output logic             sync_n
);
  localparam int NW = 2;

  logic [CNT_W-1:0] pos;
  logic             wrap;
  logic [NW-1:0]    tripped;

  period_counter #(.CNT_W(CNT_W), .SYNC_LEN(SYNC_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .pos(pos), .wrap(wrap), .sync_n(sync_n)
  );

  for (genvar w = 0; w < NW; w++) begin : g_wind
    sense_gate #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_gate (
      .clk(clk), .rst_n(rst_n), .sense_raw(sense[w]), .wrap(wrap),
      .pos(pos), .blank_len(blank_len), .tripped(tripped[w])
    );
    bridge_steer u_steer (
      .clk(clk), .rst_n(rst_n), .wrap(wrap), .tripped(tripped[w]),
      .dir(dir[w]), .slow(decay_slow[w]), .en_n(en_n),
      .en_line(inh_n[w]), .ph_hi(ph[2*w]), .ph_lo(ph[2*w+1])
    );
  end

  // R3: no winding conducts in the last clock of a period
  a_r3_off_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (!(inh_n[0] && (ph[0] || ph[1])) && !(inh_n[1] && (ph[2] || ph[3]))));

  // R2: position 0 never starts with a winding tripped
  a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) |-> (tripped == '0));

endmodule

// File: tb/sim_dual_chopper_pwm.sv
`timescale 1ns/1ps
module sim_dual_chopper_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_n = 1'b0;
  logic [1:0] sense = '0;
  logic [1:0] dir = '0;
  logic [1:0] decay_slow = '0;
  logic [7:0] blank_len = '0;
  logic [1:0] inh_n;
  logic [3:0] ph;
  logic       sync_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_chopper_pwm u0 (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .sense(sense), .dir(dir),
    .decay_slow(decay_slow), .blank_len(blank_len), .inh_n(inh_n),
    .ph(ph), .sync_n(sync_n)
  );

  // Bench-side view of the expected state, advanced at each rising edge
  int         m_pos;
  logic [1:0] m_s0, m_s1, m_trip, m_dir, m_slow;
  bit         m_chg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos <= 0; m_s0 <= '0; m_s1 <= '0; m_trip <= '0;
      m_dir <= '0; m_slow <= '0; m_chg <= 0;
    end else begin
      m_pos <= (m_pos + 1) % 256;
      m_s0  <= sense;
      m_s1  <= m_s0;
      for (int w = 0; w < 2; w++)
        m_trip[w] <= (m_pos == 255) ? 1'b0 : (m_trip[w] | (m_s1[w] && m_pos >= int'(blank_len)));
      if (m_pos == 255) begin
        m_dir  <= dir;
        m_slow <= decay_slow;
        m_chg  <= (dir != m_dir) || (decay_slow != m_slow);
      end
    end
  end

  function automatic logic [2:0] expect_leg(input int w);
    logic on;
    on = !m_trip[w] && (m_pos != 255);
    if (en_n)         return 3'b000;
    else if (m_slow[w]) return {1'b1, m_dir[w] & on, ~m_dir[w] & on};
    else              return {on, m_dir[w], ~m_dir[w]};
  endfunction

  function automatic string leg_tag(input int w);
    if (en_n)                          return "R11";
    if (m_pos == 255)                  return "R3";
    if (m_pos == 0 && m_chg)           return "R10";
    if (m_pos == 0)                    return "R2";
    if (m_trip[w] && !m_trip[1-w])     return "R7";
    if (m_trip[w] && !m_s1[w])         return "R5";
    if (m_trip[w])                     return "R4";
    if (m_pos < int'(blank_len))       return "R6";
    if (m_slow[w])                     return "R9";
    return "R8";
  endfunction

  task automatic check_all();
    logic exp_sync;
    exp_sync = !(m_pos < 16);
    total++;
    if (sync_n !== exp_sync) begin
      bad++;
      $display("FAIL R1 sync_n pos=%0d got=%b exp=%b", m_pos, sync_n, exp_sync);
    end
    for (int w = 0; w < 2; w++) begin
      logic [2:0] got, exp;
      got = {inh_n[w], ph[2*w], ph[2*w+1]};
      exp = expect_leg(w);
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s winding %0d pos=%0d got=%b exp=%b", leg_tag(w), w, m_pos, got, exp);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all();          // R1 reset state: position 0, fast decay, direction 0
    rst_n = 1'b1;
    for (int p = 0; p < 48; p++) begin
      for (int c = 0; c < 256; c++) begin
        @(negedge clk);
        check_all();
        if (p < 2) begin                 // R3: no trips, full on-time
          sense = '0; blank_len = 8'd0; dir = 2'(p); decay_slow = 2'(p);
        end else if (p < 4) begin        // R6: sense held high, blanked for 40 clocks
          sense = 2'b11; blank_len = 8'd40; decay_slow = 2'(p - 2);
        end else if (p == 4) begin       // R6: blank of 255 masks sense all period
          sense = 2'b11; blank_len = 8'd255;
        end else if (p == 5) begin       // R11: enable toggling
          sense = 2'($urandom % 4 == 0); blank_len = 8'd10;
          en_n = ($urandom % 8 == 0);
        end else begin                   // random chatter, mid-period setting changes
          en_n = ($urandom % 50 == 0);
          for (int w = 0; w < 2; w++) sense[w] = ($urandom % 48 == 0);
          if ($urandom % 90 == 0) dir = 2'($urandom);
          if ($urandom % 90 == 0) decay_slow = 2'($urandom);
          if (c == 100) blank_len = ($urandom % 5 == 0) ? 8'd255 : 8'($urandom % 96);
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule